// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block joins an I/O-side requester and a memory-side responder over one shared address/data bus and three control lines: a read request line, an acknowledge line and a data-ready line. A read runs as a fully interlocked four-phase exchange. The requester puts the address on the bus and raises the request. The responder takes the address and acknowledges. The requester then lets go of the bus and the request, and the responder withdraws its acknowledge. After a programmable latency the responder drives the word and raises data-ready. The requester takes the word and acknowledges, the responder releases the bus and data-ready, and the requester finally withdraws its acknowledge.

Neither side trusts the timing of the other. Every control line that one side receives from the other passes through a two-flop synchronizer before any state machine reacts to it. The acknowledge line is shared: it is the OR of both sides' drivers, so each side also waits to see its own release before it moves on. The bus is modelled as one drive-enable/value pair per side, resolved by a mux.

A local client gives a one-cycle start with an address and gets back a one-cycle done pulse with the read word. Start is ignored while a read is in flight. The resolved bus and the three control lines are brought out so that the exchange can be observed.

Top module: `async_rd_link`

## Requirements
- R1: While reset is low, and in the first cycle after it, done_o, rdata_o, rreq_o, ack_o, drdy_o and bus_o are all zero.
- R2: A read of address a returns the word ((a * 0x9E3779B1) XOR 0x5A5AC3C3), truncated to its low DATA_W bits, on rdata_o in the cycle done_o is high.
- R3: The request rises in the same cycle that the address (zero-extended) appears on the bus. The request falls only while the acknowledge line is high, having been seen high through the synchronizer.
- R4: The responder drops its acknowledge only after the request has been low for the synchronizer delay. It raises data-ready only when both the request and the acknowledge line are low.
- R5: The requester raises its acknowledge only after data-ready has been high for the synchronizer delay. Data-ready falls only while the acknowledge line is high.
- R6: The two sides never drive the bus in the same cycle. While data-ready rises, the bus carries the responder's word.
- R7: The latency value sampled when the address is captured (0 to 15) adds exactly that many cycles to the time from start to done.
- R8: done_o is a single-cycle pulse. All three control lines are low when it occurs. rdata_o holds its value until the next read completes.
- R9: A start presented while a read is in progress has no effect: it launches no request and produces no extra done.
- R10: A start presented in the same cycle as done_o is accepted and performs a full read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle read start from the local client |
| addr_i | input | ADDR_W | Address to read, sampled with start_i |
| lat_i | input | LAT_W | Responder latency in cycles, sampled at address capture |
| done_o | output | 1 | One-cycle pulse when a read completes |
| rdata_o | output | DATA_W | Word returned by the last completed read |
| rreq_o | output | 1 | Observed read-request line |
| ack_o | output | 1 | Observed shared acknowledge line |
| drdy_o | output | 1 | Observed data-ready line |
| bus_o | output | DATA_W | Observed resolved address/data bus |

## Verification
The two client-side events that can land on the same cycle are the completion pulse of one read and the start of the next. When they coincide, the requester has to be back in idle and accept the new start, not treat it as arriving during a busy transaction. The bench provokes this by waiting for done_o and raising start_i in that very cycle. It then judges the result by a second full exchange on the observed control lines and a second done carrying the second address's word. A start placed in the middle of a read, which must be dropped, is the contrast case. A scoreboard that fails on any unexpected done catches it.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_REQ,
    RQ_WAITD,
    RQ_ACKD,
    RQ_FIN
  } rq_state_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_HOLD,
    RS_DROP,
    RS_LAT,
    RS_SEND,
    RS_TAIL
  } rs_state_e;

  // Content of the responder's storage as a function of its index.
  function automatic logic [31:0] fill_word(input logic [31:0] idx);
    fill_word = (idx * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

endpackage

// File: rtl/async_rd_sync2.sv
module async_rd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/async_rd_requester.sv
module async_rd_requester
  import async_rd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_line_i,
  input  logic              drdy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              rreq_o,
  output logic              ack_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  rq_state_e         st_q;
  logic              rreq_q, ack_q, oe_q, done_q;
  logic [DATA_W-1:0] bus_q, rdata_q;
  logic [1:0]        sync_in, sync_out;
  logic              ack_s, drdy_s;

  assign sync_in = {drdy_i, ack_line_i};

  async_rd_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );
  assign ack_s  = sync_out[0];
  assign drdy_s = sync_out[1];

  // Named events for the checks
  logic addr_launch, data_take, start_dropped, finish_seen;
  assign addr_launch   = (st_q == RQ_IDLE) && start_i;
  assign data_take     = (st_q == RQ_WAITD) && drdy_s;
  assign start_dropped = (st_q != RQ_IDLE) && start_i;
  assign finish_seen   = (st_q == RQ_FIN) && !ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= RQ_IDLE;
      rreq_q  <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      bus_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        RQ_IDLE: if (addr_launch) begin
          bus_q  <= DATA_W'(addr_i);
          oe_q   <= 1'b1;
          rreq_q <= 1'b1;
          st_q   <= RQ_REQ;
        end
        RQ_REQ: if (ack_s) begin
          rreq_q <= 1'b0;
          oe_q   <= 1'b0;
          bus_q  <= '0;
          st_q   <= RQ_WAITD;
        end
        RQ_WAITD: if (data_take) begin
          rdata_q <= bus_i;
          ack_q   <= 1'b1;
          st_q    <= RQ_ACKD;
        end
        RQ_ACKD: if (!drdy_s) begin
          ack_q <= 1'b0;
          st_q  <= RQ_FIN;
        end
        RQ_FIN: if (finish_seen) begin
          done_q <= 1'b1;
          st_q   <= RQ_IDLE;
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assign rreq_o  = rreq_q;
  assign ack_o   = ack_q;
  assign oe_o    = oe_q;
  assign bus_o   = bus_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R3
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rreq_q) |-> $past(ack_line_i, 3));
  // R5
  dev_ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(drdy_i, 3));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_dropped |=> !$rose(rreq_q));
endmodule

// File: rtl/async_rd_responder.sv
module async_rd_responder
  import async_rd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              rreq_i,
  input  logic              ack_line_i,
  input  logic [ADDR_W-1:0] addr_bus_i,
  output logic              ack_o,
  output logic              drdy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int DEPTH = 1 << ADDR_W;

  rs_state_e         st_q;
  logic              ack_q, drdy_q, oe_q;
  logic [DATA_W-1:0] bus_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [1:0]        sync_in, sync_out;
  logic              rreq_s, ack_s;

  assign sync_in = {rreq_i, ack_line_i};

  async_rd_sync2 #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sync_in),
    .q_o   (sync_out)
  );
  assign ack_s  = sync_out[0];
  assign rreq_s = sync_out[1];

  // Named events for the checks
  logic addr_take, data_launch, lat_done;
  assign addr_take   = (st_q == RS_IDLE) && rreq_s;
  assign lat_done    = (cnt_q == '0);
  assign data_launch = (st_q == RS_LAT) && lat_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(fill_word(32'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      ack_q  <= 1'b0;
      drdy_q <= 1'b0;
      oe_q   <= 1'b0;
      bus_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        RS_IDLE: if (addr_take) begin
          addr_q <= addr_bus_i;
          cnt_q  <= lat_i;
          ack_q  <= 1'b1;
          st_q   <= RS_HOLD;
        end
        RS_HOLD: if (!rreq_s) begin
          ack_q <= 1'b0;
          st_q  <= RS_DROP;
        end
        RS_DROP: if (!ack_s) st_q <= RS_LAT;
        RS_LAT: begin
          if (data_launch) begin
            bus_q  <= mem_q[addr_q];
            oe_q   <= 1'b1;
            drdy_q <= 1'b1;
            st_q   <= RS_SEND;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RS_SEND: if (ack_s) begin
          drdy_q <= 1'b0;
          oe_q   <= 1'b0;
          bus_q  <= '0;
          st_q   <= RS_TAIL;
        end
        RS_TAIL: if (!ack_s) st_q <= RS_IDLE;
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign ack_o  = ack_q;
  assign drdy_o = drdy_q;
  assign oe_o   = oe_q;
  assign bus_o  = bus_q;

  // R4
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> $past(!rreq_i, 3));
  // R5
  drdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_q) |-> $past(ack_line_i, 3));
endmodule

// File: rtl/async_rd_link.sv
module async_rd_link #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LAT_W-1:0]  lat_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rreq_o,
  output logic              ack_o,
  output logic              drdy_o,
  output logic [DATA_W-1:0] bus_o
);
  logic              rreq, req_ack, req_oe;
  logic              rsp_ack, drdy, rsp_oe;
  logic [DATA_W-1:0] req_bus, rsp_bus, bus;
  logic              ack_line;

  // Shared acknowledge: either side may pull it high
  assign ack_line = req_ack | rsp_ack;
  // Bus resolution
  assign bus = req_oe ? req_bus : (rsp_oe ? rsp_bus : '0);

  async_rd_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .addr_i     (addr_i),
    .ack_line_i (ack_line),
    .drdy_i     (drdy),
    .bus_i      (bus),
    .rreq_o     (rreq),
    .ack_o      (req_ack),
    .oe_o       (req_oe),
    .bus_o      (req_bus),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
  );

  async_rd_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .lat_i      (lat_i),
    .rreq_i     (rreq),
    .ack_line_i (ack_line),
    .addr_bus_i (bus[ADDR_W-1:0]),
    .ack_o      (rsp_ack),
    .drdy_o     (drdy),
    .oe_o       (rsp_oe),
    .bus_o      (rsp_bus)
  );

  assign rreq_o = rreq;
  assign ack_o  = ack_line;
  assign drdy_o = drdy;
  assign bus_o  = bus;

  // R6
  bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_oe && rsp_oe));
  // R4
  drdy_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy) |-> (!ack_line && !rreq && $past(!ack_line, 3)));
endmodule

// File: tb/async_rd_link_tb_top.sv
`timescale 1ns/1ps
module async_rd_link_tb_top;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [AW-1:0] addr_i;
  logic [LW-1:0] lat_i;
  logic done_o, rreq_o, ack_o, drdy_o;
  logic [DW-1:0] rdata_o, bus_o;

  always #5 clk = ~clk;

  async_rd_link #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .lat_i(lat_i),
    .done_o(done_o), .rdata_o(rdata_o), .rreq_o(rreq_o), .ack_o(ack_o),
    .drdy_o(drdy_o), .bus_o(bus_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  int last_done_cyc = 0;
  int st_cyc = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_word = '0;
  logic prev_rreq = 0, prev_ack = 0, prev_drdy = 0, prev_done = 0;

  // Independent restatement of the stored word
  function automatic logic [DW-1:0] ref_word(input int a);
    longint unsigned p;
    p = (longint'(a) * 64'd2654435761) % 64'd4294967296;
    p = p ^ 64'd1515897795;
    return DW'(p);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rreq_o && !prev_rreq)
        chk(bus_o == DW'(cur_addr), "R3", "address on bus at request rise", bus_o, DW'(cur_addr));
      if (!rreq_o && prev_rreq)
        chk(ack_o == 1'b1, "R3", "ack high at request fall", ack_o, 1);
      if (!ack_o && prev_ack)
        chk(rreq_o == 1'b0, "R4", "request low at ack fall", rreq_o, 0);
      if (drdy_o && !prev_drdy) begin
        chk(!ack_o && !rreq_o, "R4", "ack and request low at data-ready rise",
            {ack_o, rreq_o}, 0);
        chk(bus_o == cur_word, "R6", "responder word on bus", bus_o, cur_word);
      end
      if (!drdy_o && prev_drdy)
        chk(ack_o == 1'b1, "R5", "ack high at data-ready fall", ack_o, 1);
      if (done_o) begin
        chk(!prev_done, "R8", "done lasts one cycle", prev_done, 0);
        chk(!rreq_o && !ack_o && !drdy_o, "R8", "lines idle at done",
            {rreq_o, ack_o, drdy_o}, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata_o == e, "R2", "read word", rdata_o, e);
        end
        done_cnt++;
        last_done_cyc = cyc;
      end
    end
    prev_rreq = rreq_o;
    prev_ack  = ack_o;
    prev_drdy = drdy_o;
    prev_done = done_o;
  end

  task automatic issue(input int a, input int l);
    @(negedge clk);
    start_i  = 1'b1;
    addr_i   = AW'(a);
    lat_i    = LW'(l);
    cur_addr = AW'(a);
    cur_word = ref_word(a);
    exp_q.push_back(ref_word(a));
    st_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    wait (cyc >= 100000);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int d0, d15, d6;
    logic [DW-1:0] held;
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0; lat_i = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!done_o && rdata_o == '0, "R1", "done/rdata in reset", {done_o, rdata_o}, 0);
    chk(!rreq_o && !ack_o && !drdy_o && bus_o == '0, "R1", "lines in reset",
        {rreq_o, ack_o, drdy_o, bus_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !rreq_o && !ack_o && !drdy_o && bus_o == '0, "R1", "idle after reset",
        {done_o, rreq_o, ack_o, drdy_o, bus_o}, 0);

    // R2: every address, assorted latencies
    n = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      issue(a, (a * 5) % 16);
      n++;
      wait_done(n);
    end

    // R7: latency adds exactly that many cycles
    issue(3, 0);  n++; wait_done(n); d0  = last_done_cyc - st_cyc;
    issue(3, 15); n++; wait_done(n); d15 = last_done_cyc - st_cyc;
    issue(3, 6);  n++; wait_done(n); d6  = last_done_cyc - st_cyc;
    chk(d15 - d0 == 15, "R7", "latency 15 extra cycles", d15 - d0, 15);
    chk(d6 - d0 == 6, "R7", "latency 6 extra cycles", d6 - d0, 6);

    // R9: start during a read is dropped
    issue(5, 2); n++;
    repeat (3) @(negedge clk);
    start_i = 1'b1; addr_i = AW'(9);
    @(negedge clk);
    start_i = 1'b0;
    wait_done(n);
    held = rdata_o;
    repeat (80) @(negedge clk);
    chk(done_cnt == n, "R9", "no extra done after dropped start", done_cnt, n);
    chk(rdata_o == ref_word(5), "R9", "result from first address only", rdata_o, ref_word(5));
    chk(rdata_o == held, "R8", "rdata held while idle", rdata_o, held);

    // R10: start in the same cycle as done
    issue(12, 1); n++;
    do @(negedge clk); while (!done_o);
    start_i  = 1'b1;
    addr_i   = AW'(7);
    lat_i    = LW'(4);
    cur_addr = AW'(7);
    cur_word = ref_word(7);
    exp_q.push_back(ref_word(7));
    @(negedge clk);
    start_i = 1'b0;
    n++;
    wait_done(n);
    chk(rdata_o == ref_word(7), "R10", "back-to-back read accepted", rdata_o, ref_word(7));
    repeat (60) @(negedge clk);
    chk(done_cnt == n, "R10", "done count", done_cnt, n);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule